// File: doc/BRIEF.md
# Masked Vector OR Unit

This block computes the bitwise OR of two 512-bit vector operands and registers the result. Each operand is handled as sixteen 32-bit elements. A per-element write mask decides which elements take the OR result. For an element whose mask bit is clear, the block applies one of two policies. It can keep the element of the previous destination value, or it can clear the element to zero. The same 32-bit element datapath serves both the floating-point and the integer doubleword forms of the operation, because bitwise OR does not depend on how the bits are interpreted.

The second operand can be replaced by a single 32-bit scalar that is copied into every element before the OR. When masking is not enabled, every element receives the OR result, and the mask and the zeroing flag are not used. A request is accepted on a rising clock edge while `in_valid` is high. The result appears on the next cycle, together with a one-cycle valid pulse.

Top module: `simd_or_mask_unit`

## Requirements
- R1: While `rst_n` is sampled low at a clock edge, the block clears `out_valid` and `out_data` to zero.
- R2: Element i occupies bits [32*i+31 : 32*i] of every vector port, with element 0 at the least significant end, and mask bit i controls element i.
- R3: With `mask_en` low, every output element is the OR of the matching elements of the two sources, whatever the values of `wmask` and `zero_mode`.
- R4: With `mask_en` high and `zero_mode` low (merge policy), an element whose mask bit is 0 takes the matching element of `old_dst` unchanged.
- R5: With `mask_en` high and `zero_mode` high (zeroing policy), an element whose mask bit is 0 is all zeros.
- R6: With `mask_en` high, an element whose mask bit is 1 receives the OR result under either policy.
- R7: With `bcast_en` high, the second operand is `bcast_scalar` copied into all sixteen elements, and `src_b` is not used.
- R8: Bits 16 and above of `wmask` have no effect on the result.
- R9: A mask of 0x00FF updates only elements 0 to 7 (the low 256 bits). Elements 8 to 15 follow the merge or zeroing policy.
- R10: A request accepted while `in_valid` is high produces `out_valid` high on the next cycle, with the result on `out_data`. A cycle with `in_valid` low gives `out_valid` low on the next cycle and leaves `out_data` unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; all state changes on the rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| in_valid | input | 1 | Request strobe; the inputs are captured while it is high |
| src_a | input | 512 | First source vector |
| src_b | input | 512 | Second source vector, used when broadcast is off |
| old_dst | input | 512 | Previous destination value, used by the merge policy |
| wmask | input | 64 | Write mask; only the low 16 bits are used |
| mask_en | input | 1 | 1 = apply the write mask |
| zero_mode | input | 1 | 1 = clear unselected elements, 0 = merge them |
| bcast_en | input | 1 | 1 = replace the second source with the broadcast scalar |
| bcast_scalar | input | 32 | Scalar copied into every element when broadcast is on |
| out_valid | output | 1 | One-cycle pulse that marks a new result |
| out_data | output | 512 | Registered result vector |

## Verification
The assertions assume that every input is at a known level whenever `in_valid` is high at a clock edge. They also assume that the inputs stay stable across that edge, because the checker compares the output with the values sampled one cycle earlier. The bench drives all inputs on the falling edge, so each value is settled well before the capturing edge. Random requests are mixed with idle cycles, and the idle cycles carry fresh data on the input ports, which exercises the hold check without ever driving an unknown value.

// File: rtl/vor_pkg.sv
// Package: vor_pkg
// Holds the default geometry and the masking policy type that the masked
// vector OR unit and its submodules share.
package vor_pkg;

    localparam int unsigned DEF_ELEM_W   = 32;
    localparam int unsigned DEF_NUM_ELEM = 16;
    localparam int unsigned DEF_MASK_W   = 64;

    // Treatment of one element of the destination.
    typedef enum logic [1:0] {
        POL_WRITE = 2'd0,   // element takes the OR result
        POL_KEEP  = 2'd1,   // element keeps the old destination value
        POL_CLEAR = 2'd2    // element is forced to zero
    } elem_pol_e;

    // Works out the policy of one element from its mask bit and the mode flags.
    function automatic elem_pol_e pick_policy(input logic mbit,
                                              input logic men,
                                              input logic zmode);
        if (!men || mbit) return POL_WRITE;
        if (zmode)        return POL_CLEAR;
        return POL_KEEP;
    endfunction

endpackage

// File: rtl/vor_operand_sel.sv
// Module: vor_operand_sel
// Builds the effective second operand. It either passes the source vector
// through or copies one scalar into every element.
// Assumes: the vector width is NUM_ELEM * ELEM_W, and the scalar is one element wide.
module vor_operand_sel #(
    parameter int unsigned ELEM_W   = vor_pkg::DEF_ELEM_W,
    parameter int unsigned NUM_ELEM = vor_pkg::DEF_NUM_ELEM,
    localparam int unsigned VEC_W   = ELEM_W * NUM_ELEM
) (
    input  logic [VEC_W-1:0]  vec_in,
    input  logic [ELEM_W-1:0] scalar_in,
    input  logic              bcast,
    output logic [VEC_W-1:0]  vec_out
);

    // Select the operand one element slice at a time.
    for (genvar e = 0; e < NUM_ELEM; e++) begin : g_slice
        always_comb begin
            vec_out[e*ELEM_W +: ELEM_W] = bcast ? scalar_in
                                                : vec_in[e*ELEM_W +: ELEM_W];
        end
    end

endmodule

// File: rtl/vor_lane.sv
// Module: vor_lane
// One element lane. It ORs its two operand slices and then applies the
// write, keep or clear policy that its mask bit and the mode flags select.
// Assumes: the mode flags are common to all lanes, and the mask bit is this lane's own.
module vor_lane
    import vor_pkg::*;
#(
    parameter int unsigned ELEM_W = DEF_ELEM_W
) (
    input  logic [ELEM_W-1:0] opa,
    input  logic [ELEM_W-1:0] opb,
    input  logic [ELEM_W-1:0] prev,
    input  logic              mbit,
    input  logic              men,
    input  logic              zmode,
    output logic [ELEM_W-1:0] res
);

    elem_pol_e pol;

    // Decide what this element of the destination receives.
    always_comb pol = pick_policy(mbit, men, zmode);

    // Drive the lane result from the chosen policy.
    always_comb begin
        unique case (pol)
            POL_WRITE: res = opa | opb;
            POL_KEEP:  res = prev;
            POL_CLEAR: res = '0;
            default:   res = '0;
        endcase
    end

endmodule

// File: rtl/vor_out_reg.sv
// Module: vor_out_reg
// Result register and valid pulse. It loads a new vector only while a
// request is present and holds the vector at all other times.
// Assumes: rst_n is synchronous and active low.
module vor_out_reg #(
    parameter int unsigned VEC_W = vor_pkg::DEF_ELEM_W * vor_pkg::DEF_NUM_ELEM
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [VEC_W-1:0] d,
    output logic             q_valid,
    output logic [VEC_W-1:0] q
);

    // Capture the result and raise the valid pulse for one cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q_valid <= 1'b0;
            q       <= '0;
        end else begin
            q_valid <= load;
            if (load) q <= d;
        end
    end

endmodule

// File: rtl/simd_or_mask_unit.sv
// Module: simd_or_mask_unit
// Masked vector OR unit. It ORs two vectors element by element, with an
// optional broadcast second operand and merge or zeroing write masking,
// and registers the result with one cycle of latency.
// Assumes: the mask is at least NUM_ELEM bits wide; bits above NUM_ELEM are not used.
module simd_or_mask_unit #(
    parameter int unsigned ELEM_W   = vor_pkg::DEF_ELEM_W,
    parameter int unsigned NUM_ELEM = vor_pkg::DEF_NUM_ELEM,
    parameter int unsigned MASK_W   = vor_pkg::DEF_MASK_W,
    localparam int unsigned VEC_W   = ELEM_W * NUM_ELEM
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_valid,
    input  logic [VEC_W-1:0]  src_a,
    input  logic [VEC_W-1:0]  src_b,
    input  logic [VEC_W-1:0]  old_dst,
    input  logic [MASK_W-1:0] wmask,
    input  logic              mask_en,
    input  logic              zero_mode,
    input  logic              bcast_en,
    input  logic [ELEM_W-1:0] bcast_scalar,
    output logic              out_valid,
    output logic [VEC_W-1:0]  out_data
);

    logic [VEC_W-1:0]    eff_b;
    logic [VEC_W-1:0]    lane_res;
    logic [NUM_ELEM-1:0] elem_mask;

    // Keep only the mask bits that have an element to control.
    always_comb elem_mask = wmask[NUM_ELEM-1:0];

    // The upper mask bits are not used at this element size.
    if (MASK_W > NUM_ELEM) begin : g_hi_mask
        logic unused_hi_mask;
        always_comb unused_hi_mask = ^wmask[MASK_W-1:NUM_ELEM];
    end

    vor_operand_sel #(
        .ELEM_W   (ELEM_W),
        .NUM_ELEM (NUM_ELEM)
    ) opsel_i (
        .vec_in    (src_b),
        .scalar_in (bcast_scalar),
        .bcast     (bcast_en),
        .vec_out   (eff_b)
    );

    for (genvar e = 0; e < NUM_ELEM; e++) begin : g_lane
        vor_lane #(
            .ELEM_W (ELEM_W)
        ) lane_i (
            .opa   (src_a   [e*ELEM_W +: ELEM_W]),
            .opb   (eff_b   [e*ELEM_W +: ELEM_W]),
            .prev  (old_dst [e*ELEM_W +: ELEM_W]),
            .mbit  (elem_mask[e]),
            .men   (mask_en),
            .zmode (zero_mode),
            .res   (lane_res[e*ELEM_W +: ELEM_W])
        );
    end

    vor_out_reg #(
        .VEC_W (VEC_W)
    ) oreg_i (
        .clk     (clk),
        .rst_n   (rst_n),
        .load    (in_valid),
        .d       (lane_res),
        .q_valid (out_valid),
        .q       (out_data)
    );

endmodule

// File: rtl/vor_checker.sv
// Module: vor_checker
// Temporal checks on the ports of the masked vector OR unit. The module is
// attached to the top module with the bind statement at the end of this file.
// Assumes: the inputs are known and stable across each capturing edge.
module vor_checker #(
    parameter int unsigned ELEM_W   = vor_pkg::DEF_ELEM_W,
    parameter int unsigned NUM_ELEM = vor_pkg::DEF_NUM_ELEM,
    parameter int unsigned MASK_W   = vor_pkg::DEF_MASK_W,
    localparam int unsigned VEC_W   = ELEM_W * NUM_ELEM
) (
    input logic              clk,
    input logic              rst_n,
    input logic              in_valid,
    input logic [VEC_W-1:0]  src_a,
    input logic [VEC_W-1:0]  src_b,
    input logic [VEC_W-1:0]  old_dst,
    input logic [MASK_W-1:0] wmask,
    input logic              mask_en,
    input logic              zero_mode,
    input logic              bcast_en,
    input logic [ELEM_W-1:0] bcast_scalar,
    input logic              out_valid,
    input logic [VEC_W-1:0]  out_data
);

    // R10: an accepted request is followed by a valid pulse.
    a_r10_valid_follows: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> out_valid);

    // R10: an idle cycle drops valid and holds the result.
    a_r10_idle_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> (!out_valid && $stable(out_data)));

    // R3: without masking, the plain OR of the two sources comes out.
    a_r3_unmasked_or: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && !mask_en && !bcast_en) |=>
            (out_data == ($past(src_a) | $past(src_b))));

    // R7: broadcast replaces the second source with the copied scalar.
    a_r7_bcast_or: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && !mask_en && bcast_en) |=>
            (out_data == ($past(src_a) | {NUM_ELEM{$past(bcast_scalar)}})));

    // R4: merge policy with an empty mask passes the old destination through.
    a_r4_merge_empty: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && mask_en && !zero_mode && (wmask[NUM_ELEM-1:0] == '0)) |=>
            (out_data == $past(old_dst)));

    // R5: zeroing policy with an empty mask gives all zeros.
    a_r5_zero_empty: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && mask_en && zero_mode && (wmask[NUM_ELEM-1:0] == '0)) |=>
            (out_data == '0));

endmodule

bind simd_or_mask_unit vor_checker #(
    .ELEM_W   (ELEM_W),
    .NUM_ELEM (NUM_ELEM),
    .MASK_W   (MASK_W)
) chk_i (
    .clk          (clk),
    .rst_n        (rst_n),
    .in_valid     (in_valid),
    .src_a        (src_a),
    .src_b        (src_b),
    .old_dst      (old_dst),
    .wmask        (wmask),
    .mask_en      (mask_en),
    .zero_mode    (zero_mode),
    .bcast_en     (bcast_en),
    .bcast_scalar (bcast_scalar),
    .out_valid    (out_valid),
    .out_data     (out_data)
);

// File: tb/simd_or_mask_unit_tb_top.sv
`timescale 1ns/1ps
// Bench for the masked vector OR unit: directed corner cases followed by
// seeded random requests, each compared with a value computed from the requirements.
module simd_or_mask_unit_tb_top;

    localparam int VW = 512;
    localparam int NE = 16;

    logic           clk = 1'b0;
    logic           rst_n = 1'b0;
    logic           in_valid = 1'b0;
    logic [VW-1:0]  src_a = '0, src_b = '0, old_dst = '0;
    logic [63:0]    wmask = '0;
    logic           mask_en = 1'b0, zero_mode = 1'b0, bcast_en = 1'b0;
    logic [31:0]    bcast_scalar = '0;
    logic           out_valid;
    logic [VW-1:0]  out_data;

    int n_chk = 0;
    int n_bad = 0;
    bit finished = 1'b0;

    always #2 clk = ~clk;

    simd_or_mask_unit dut_i (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid),
        .src_a(src_a), .src_b(src_b), .old_dst(old_dst),
        .wmask(wmask), .mask_en(mask_en), .zero_mode(zero_mode),
        .bcast_en(bcast_en), .bcast_scalar(bcast_scalar),
        .out_valid(out_valid), .out_data(out_data)
    );

    // Returns a 512-bit random vector.
    function automatic logic [VW-1:0] rvec();
        logic [VW-1:0] v;
        for (int i = 0; i < NE; i++) v[i*32 +: 32] = $urandom;
        return v;
    endfunction

    // Expected result taken from the requirement text: element i is bits
    // [32i+31:32i] and is controlled by mask bit i; mask bits 16 and above are ignored.
    function automatic logic [VW-1:0] model(logic [VW-1:0] a, logic [VW-1:0] b,
            logic [VW-1:0] od, logic [63:0] m, logic men, logic zm,
            logic bc, logic [31:0] sc);
        logic [VW-1:0] r;
        for (int i = 0; i < NE; i++) begin
            logic [31:0] bb;
            bb = bc ? sc : b[i*32 +: 32];
            if (!men || m[i]) r[i*32 +: 32] = a[i*32 +: 32] | bb;
            else if (zm)      r[i*32 +: 32] = 32'h0;
            else              r[i*32 +: 32] = od[i*32 +: 32];
        end
        return r;
    endfunction

    task automatic check_vec(string tag, logic [VW-1:0] act, logic [VW-1:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: out_data actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic check_bit(string tag, logic act, logic exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: out_valid actual %b expected %b", tag, act, exp);
        end
    endtask

    // Drives one request at the falling edge and checks it one cycle later.
    task automatic run_req(string tag, logic [VW-1:0] a, logic [VW-1:0] b,
            logic [VW-1:0] od, logic [63:0] m, logic men, logic zm,
            logic bc, logic [31:0] sc);
        src_a = a; src_b = b; old_dst = od; wmask = m;
        mask_en = men; zero_mode = zm; bcast_en = bc; bcast_scalar = sc;
        in_valid = 1'b1;
        @(negedge clk);
        in_valid = 1'b0;
        check_bit({tag, " R10"}, out_valid, 1'b1);
        check_vec(tag, out_data, model(a, b, od, m, men, zm, bc, sc));
    endtask

    initial begin
        #(4 * 150000);
        if (!finished) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        logic [VW-1:0] ones, twos, ffs, held;
        void'($urandom(32'd20240611));
        ones = {64{8'h01}}; twos = {64{8'h02}}; ffs = {VW{1'b1}};

        // R1: reset clears the output.
        repeat (3) @(negedge clk);
        check_bit("R1 reset valid", out_valid, 1'b0);
        check_vec("R1 reset data", out_data, '0);
        rst_n = 1'b1;
        @(negedge clk);

        // R3: no masking, mask and zeroing ignored.
        run_req("R3 unmasked", ones, twos, ffs, 64'h0, 1'b0, 1'b1, 1'b0, 32'h0);
        // R9/R4: merge with a 0x00FF mask keeps the upper half.
        run_req("R9 R4 merge 00FF", ones, twos, ffs, 64'h00FF, 1'b1, 1'b0, 1'b0, 32'h0);
        // R9/R5: zeroing with a 0x00FF mask clears the upper half.
        run_req("R9 R5 zero 00FF", ones, twos, ffs, 64'h00FF, 1'b1, 1'b1, 1'b0, 32'h0);
        // R6: a full mask writes everything under both policies.
        run_req("R6 full merge", rvec(), rvec(), rvec(), 64'hFFFF, 1'b1, 1'b0, 1'b0, 32'h0);
        run_req("R6 full zero", rvec(), rvec(), rvec(), 64'hFFFF, 1'b1, 1'b1, 1'b0, 32'h0);
        // R2: a single mask bit selects exactly element 0 and element 15.
        run_req("R2 elem0", rvec(), rvec(), rvec(), 64'h0001, 1'b1, 1'b1, 1'b0, 32'h0);
        run_req("R2 elem15", rvec(), rvec(), rvec(), 64'h8000, 1'b1, 1'b0, 1'b0, 32'h0);
        // R8: upper mask bits alone change nothing.
        run_req("R8 high mask zero", rvec(), rvec(), rvec(), 64'hFFFF_FFFF_FFFF_0000, 1'b1, 1'b1, 1'b0, 32'h0);
        run_req("R8 high mask merge", rvec(), rvec(), rvec(), 64'hABCD_0000_5A5A_0000, 1'b1, 1'b0, 1'b0, 32'h0);
        // R7: broadcast ignores src_b.
        run_req("R7 bcast", '0, ffs, rvec(), 64'h0, 1'b0, 1'b0, 1'b1, 32'h8000_0001);
        run_req("R7 bcast masked", rvec(), rvec(), rvec(), 64'h0F0F, 1'b1, 1'b0, 1'b1, $urandom);

        // R10: idle cycle with new input data holds the output.
        held = out_data;
        src_a = rvec(); src_b = rvec(); old_dst = rvec(); wmask = 64'hFFFF; mask_en = 1'b0;
        @(negedge clk);
        check_bit("R10 idle valid", out_valid, 1'b0);
        check_vec("R10 idle hold", out_data, held);

        // Random mix of requests and idle cycles.
        for (int k = 0; k < 400; k++) begin
            if ($urandom_range(3, 0) == 0) begin
                held = out_data;
                src_a = rvec();
                @(negedge clk);
                check_bit("R10 rand idle", out_valid, 1'b0);
                check_vec("R10 rand idle", out_data, held);
            end else begin
                run_req("R3 R4 R5 R6 R7 random", rvec(), rvec(), rvec(),
                        {$urandom, $urandom}, 1'($urandom), 1'($urandom),
                        1'($urandom), $urandom);
            end
        end

        // R1: reset in mid-run clears the output again.
        rst_n = 1'b0;
        @(negedge clk);
        check_bit("R1 rerst valid", out_valid, 1'b0);
        check_vec("R1 rerst data", out_data, '0);

        finished = 1'b1;
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

endmodule